// File: doc/BRIEF.md
# Wake-Up Event Debouncer with Sticky Status

This block watches five slow, noise-prone event lines: an active-low wake key, a real-time-clock alarm, a modem ring indicate, a power-adapter condition and a hot-sync GPIO line. It runs on the low-power 4 kHz clock. Each line passes through a two-flop synchroniser. A divide-by-16 counter makes a 250 Hz sample strobe, and the line is sampled only on that strobe. An event is accepted only when four consecutive samples show it active.

Each accepted event sets its own sticky status bit. The bit stays set until software writes a 1 to its position. The block drives two outputs from the status bits. The interrupt output is the OR of the status bits that software has enabled. The wake-up output is the OR of all status bits and no enable gates it. Software uses one 16-bit register for both jobs. It reads the status and the enables from that register, and in the same write it clears status bits and loads the enables.

Top module: `wk_wake_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all status bits and all enable bits go to 0, so `reg_rdata`, `irq` and `wake` read 0.
- R2: A status bit is set only when its synchronised input has been active on four consecutive sample strobes. An active pulse too short to cover four strobes sets nothing.
- R3: The sample strobe occurs once every 16 clock cycles, counted from reset.
- R4: A status bit stays set after its input returns to inactive.
- R5: A write with a 1 in bit i (i in 0..4) clears status bit i. A 0 in that position leaves the bit unchanged. For example, writing 0x10 clears the wake-key bit.
- R6: Write data bits 11:7 load the five enable bits, in the same source order as the status bits. Bit 11 is the wake-key enable. The enables read back at bits 11:7, and bits 15:12 and 6:5 read 0.
- R7: `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: `wake` is high whenever any status bit is 1, whatever the enables are. A hot-sync event on its own raises `wake`.
- R9: If a set from a new event and a software clear reach the same bit in the same cycle, the bit ends up set.
- R10: Status bit positions are: bit 0 RTC alarm, bit 1 ring indicate, bit 2 adapter condition, bit 3 hot-sync, bit 4 wake key. The wake key is active when `wake_key_n` is low, and every other input is active high. A wake-key event therefore reads as 0x10.
- R11: An event sets its bit once, when the filtered input becomes active. If software clears the bit while the input is still held active, the bit stays clear until the input goes inactive and then qualifies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 kHz low-power clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wake_key_n | input | 1 | Wake key, active low, asynchronous |
| rtc_alarm | input | 1 | RTC alarm, asynchronous |
| ring_ind | input | 1 | Modem ring indicate, asynchronous |
| adapter_evt | input | 1 | Power-adapter condition, asynchronous |
| hotsync | input | 1 | Hot-sync GPIO wake line, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data: bits 4:0 clear status, bits 11:7 load enables |
| reg_rdata | output | 16 | Read data: enables at 11:7, status at 4:0 |
| irq | output | 1 | Masked interrupt request |
| wake | output | 1 | Unmaskable wake-up request |

## Verification
A status bit rises on the edge after the filter sees its fourth active sample. The delay from an input edge is two synchroniser cycles, up to 16 cycles to the next strobe, three more strobes, and one cycle to register the set. A write changes the status or the enables on the edge that samples it. `irq`, `wake` and `reg_rdata` follow the registers in the same cycle. The bench keeps a behavioural model made of a cycle counter and per-input run lengths, advances it on every rising edge and compares all outputs 2 ns after that edge. Named checks at phase boundaries test short pulses, held events, masked and unmasked sources and a clear that collides with a set.

// File: rtl/wk_pkg.sv
// Shared constants for the wake-up event block: source count, status bit
// positions and the register layout. Assumes five event sources.
package wk_pkg;
    localparam int NSRC      = 5;
    localparam int SRC_RTC   = 0;
    localparam int SRC_RING  = 1;
    localparam int SRC_ADP   = 2;
    localparam int SRC_HSYNC = 3;
    localparam int SRC_KEY   = 4;
    localparam int EN_BASE   = 7;
    localparam int REG_W     = 16;
endpackage

// File: rtl/wk_sync.sv
// Two-flop synchroniser for W independent asynchronous lines.
// Assumes the inputs are already active-high; the reset value is inactive.
module wk_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;

    // Two register stages that bring the asynchronous lines into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/wk_tick.sv
// Sample strobe generator. Divides the block clock by DIV and gives a
// one-cycle strobe in the last cycle of each period. Assumes DIV >= 2.
module wk_tick #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Free-running counter that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R3: two strobes are never adjacent
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wk_filter.sv
// Debounce filter for one synchronised line. On each strobe it shifts in a
// sample and flags the line active once SAMPLES consecutive samples are 1.
// It emits a one-cycle pulse when the filtered level turns active.
module wk_filter #(
    parameter int SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic rise
);
    logic [SAMPLES-1:0] hist_q;
    logic               filt;
    logic               filt_q;

    // Sample history, advanced only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (tick) hist_q <= {hist_q[SAMPLES-2:0], din};
    end

    assign filt = &hist_q;

    // Filtered level delayed by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= filt;
    end

    assign rise = filt & ~filt_q;

    // R2: a qualified event appears only on the cycle after a strobe
    a_r2_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(tick));
    // R11: the event pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/wk_wake_ctrl.sv
// Wake-up event controller. It debounces five event lines and keeps a
// write-one-to-clear sticky status bit per line, plus an enable bit per line.
// It drives a masked interrupt and an unmaskable wake-up request.
// Assumes clk is the 4 kHz low-power clock and that register writes are
// single-cycle strobes in the same domain.
module wk_wake_ctrl
    import wk_pkg::*;
#(
    parameter int DIV     = 16,
    parameter int SAMPLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_key_n,
    input  logic             rtc_alarm,
    input  logic             ring_ind,
    input  logic             adapter_evt,
    input  logic             hotsync,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             wake
);
    localparam int GAP_LO = EN_BASE - NSRC;
    localparam int GAP_HI = REG_W - EN_BASE - NSRC;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] synced;
    logic [NSRC-1:0] set_evt;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] en_q;
    logic            tick;
    logic            unused_wdata_bits;

    // Gather the inputs into source order, active high.
    always_comb begin
        raw            = '0;
        raw[SRC_RTC]   = rtc_alarm;
        raw[SRC_RING]  = ring_ind;
        raw[SRC_ADP]   = adapter_evt;
        raw[SRC_HSYNC] = hotsync;
        raw[SRC_KEY]   = ~wake_key_n;
    end

    wk_sync #(.W(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw),
        .sync_out (synced)
    );

    wk_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_filt
        wk_filter #(.SAMPLES(SAMPLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .din   (synced[i]),
            .rise  (set_evt[i])
        );
    end

    assign clr = reg_we ? reg_wdata[NSRC-1:0] : '0;

    // Sticky status: a new event sets the bit, a software 1 clears it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | set_evt;
    end

    // Interrupt enables, loaded on every register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (reg_we) en_q <= reg_wdata[EN_BASE +: NSRC];
    end

    assign reg_rdata = {{GAP_HI{1'b0}}, en_q, {GAP_LO{1'b0}}, status_q};
    assign irq       = |(status_q & en_q);
    assign wake      = |status_q;

    assign unused_wdata_bits = ^{reg_wdata[REG_W-1:EN_BASE+NSRC], reg_wdata[EN_BASE-1:NSRC]};

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R9: a set that collides with a clear leaves the bit set
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> status_q[i]);
        // R5: a clear with no event leaves the bit at 0
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && reg_wdata[i] && !set_evt[i]) |=> !status_q[i]);
        // R4: with no event and no clear, the bit holds
        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_evt[i] && !(reg_we && reg_wdata[i])) |=> $stable(status_q[i]));
    end
endmodule

// File: tb/sim_wk_wake_ctrl.sv
module sim_wk_wake_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_n = 1'b1, rtc = 1'b0, ring = 1'b0, adp = 1'b0, hs = 1'b0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, wake;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wk_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wake_key_n(key_n), .rtc_alarm(rtc),
        .ring_ind(ring), .adapter_evt(adp), .hotsync(hs), .reg_we(we),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .wake(wake)
    );

    // Behavioural reference: run lengths of active samples per source
    int   s1 [5], s2 [5], run [5];
    bit   pf [5];
    int   mcnt;
    logic [4:0] mst, men;

    task automatic model_step();
        bit x [5];
        bit rise [5];
        bit tk;
        x[0] = rtc; x[1] = ring; x[2] = adp; x[3] = hs; x[4] = ~key_n;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin s1[i] = 0; s2[i] = 0; run[i] = 0; pf[i] = 0; end
            mcnt = 0; mst = '0; men = '0;
        end else begin
            tk = (mcnt == 15);
            for (int i = 0; i < 5; i++) begin
                rise[i] = (run[i] >= 4) && !pf[i];
                pf[i]   = (run[i] >= 4);
                if (tk) run[i] = (s2[i] != 0) ? ((run[i] < 4) ? run[i] + 1 : 4) : 0;
                s2[i] = s1[i];
                s1[i] = x[i];
            end
            for (int i = 0; i < 5; i++) begin
                if (we && wdata[i]) mst[i] = 1'b0;
                if (rise[i])        mst[i] = 1'b1;
            end
            if (we) men = wdata[11:7];
            mcnt = (mcnt + 1) % 16;
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Advance the model at each edge and compare all outputs shortly after
    always @(posedge clk) begin
        logic [15:0] exp_rd;
        model_step();
        #2;
        exp_rd = {4'b0, men, 2'b0, mst};
        chk(rdata == exp_rd, {cur_req, " rdata"}, rdata, exp_rd);
        chk(irq == |(mst & men), {cur_req, " R7 irq"}, irq, |(mst & men));
        chk(wake == |mst, {cur_req, " R8 wake"}, wake, |mst);
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0; wdata = '0;
    endtask

    initial begin
        bit saw;
        // R1: reset state
        idle(4);
        chk(rdata == 16'h0 && !irq && !wake, "R1 reset", rdata, 0);
        rst_n = 1'b1;
        idle(2);
        // R2: short wake-key pulse is rejected
        cur_req = "R2";
        key_n = 1'b0; idle(40); key_n = 1'b1; idle(100);
        chk(rdata == 16'h0, "R2 short pulse ignored", rdata, 0);
        // R3/R10: held RTC alarm qualifies after four strobes
        cur_req = "R3 R10";
        rtc = 1'b1; idle(90);
        chk(rdata == 16'h0001, "R10 rtc bit0", rdata, 16'h0001);
        chk(wake && !irq, "R8 wake while masked", {wake, irq}, 2'b10);
        // R4: bit stays after input drops
        cur_req = "R4";
        rtc = 1'b0; idle(100);
        chk(rdata == 16'h0001, "R4 sticky", rdata, 16'h0001);
        // R5: zero write no effect, one clears
        cur_req = "R5";
        wr(16'h0000); idle(2);
        chk(rdata == 16'h0001, "R5 write zero keeps", rdata, 16'h0001);
        wr(16'h0001); idle(2);
        chk(rdata == 16'h0000, "R5 write one clears", rdata, 0);
        // R6/R7: enable wake key, raise it
        cur_req = "R6 R7";
        wr(16'hF860); idle(2);
        chk(rdata == 16'h0800, "R6 enable readback", rdata, 16'h0800);
        key_n = 1'b0; idle(90);
        chk(rdata == 16'h0810, "R10 key reads 0x10", rdata, 16'h0810);
        chk(irq == 1'b1, "R7 irq enabled", irq, 1);
        // R11: clear while held stays clear
        cur_req = "R11";
        wr(16'h0810); idle(100);
        chk(rdata == 16'h0800 && !irq, "R11 no reset while held", rdata, 16'h0800);
        key_n = 1'b1; idle(80);
        key_n = 1'b0; idle(90); key_n = 1'b1;
        chk(rdata == 16'h0810, "R11 requalify sets", rdata, 16'h0810);
        wr(16'h0010); idle(2);
        // R8: hot-sync alone wakes with mask cleared
        cur_req = "R8";
        hs = 1'b1; idle(90); hs = 1'b0;
        chk(rdata == 16'h0008 && wake && !irq, "R8 hotsync wake unmasked", rdata, 16'h0008);
        wr(16'h0008); idle(2);
        // R9: continuous clears while adapter event forms
        cur_req = "R9";
        saw = 1'b0;
        adp = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); we = 1'b1; wdata = 16'h0004;
            if (rdata[2]) saw = 1'b1;
        end
        @(negedge clk); we = 1'b0; wdata = '0; adp = 1'b0;
        chk(saw, "R9 set wins over clear", saw, 1);
        idle(4);
        chk(rdata == 16'h0000, "R9 cleared afterwards", rdata, 0);
        // R10: ring indicate bit1
        cur_req = "R10";
        ring = 1'b1; idle(90); ring = 1'b0;
        chk(rdata == 16'h0002, "R10 ring bit1", rdata, 16'h0002);
        // R1: reset mid-run
        cur_req = "R1";
        wr(16'h0F80);
        rst_n = 1'b0; idle(3);
        chk(rdata == 16'h0 && !wake, "R1 reset clears", rdata, 0);
        rst_n = 1'b1; idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule